// File: doc/BRIEF.md
# Exact Recency Tracker for One Cache Set

This block keeps a full least-recently-used ordering of the ways of a single cache set. Each way owns an age counter as wide as the way index. The counters always hold a permutation of 0 to WAYS-1. The way at WAYS-1 is the most recently used one, and the way at 0 is the least recently used one and so the replacement choice.

A requester pulses the access strobe together with a way index. On that clock edge the accessed way jumps to the top age. Every other way that was younger than it moves down by one, and every way that was older keeps its age. The victim index is decoded combinationally from the current counters. The counter values are exported so that a wrapper can store them in a per-set array, or so that they can be observed. WAYS must be a power of two and at least 2. With WAYS=2 the state is one bit per way, and the victim is always the way not touched last.

Top module: `lru_age_tracker`

## Requirements
- R1: While rst_ni is low, way j's counter (bits [j*IDX_W +: IDX_W] of ages_o) holds the value j, so way 0 is the victim after reset.
- R2: On a clock edge with touch_i high, the counter of way touch_way_i becomes WAYS-1.
- R3: On that same edge, every other way whose counter is greater than the accessed way's previous counter is decremented by one.
- R4: On that same edge, every other way whose counter is less than the accessed way's previous counter keeps its value.
- R5: An access to the way whose counter already equals WAYS-1 leaves every counter unchanged.
- R6: On an edge with touch_i low, no counter changes, whatever value touch_way_i has.
- R7: victim_way_o is, in the same cycle and with no register, the index of the way whose counter is 0.
- R8: At every cycle after reset, the counters form a permutation of 0..WAYS-1.
- R9: After any sequence of accesses, victim_way_o equals the way whose last access is the oldest, where ways never accessed rank by their reset order.
- R10: With WAYS=2, after any access to way w the victim is the other way, 1-w.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| touch_i | input | 1 | Access strobe, one access per cycle |
| touch_way_i | input | IDX_W | Index of the accessed way |
| victim_way_o | output | IDX_W | Way to replace (counter equal to zero) |
| ages_o | output | WAYS*IDX_W | Packed counters, way j in bits [j*IDX_W +: IDX_W] |

## Verification
The hardest state to reach is an access to a way in the middle of the order, one with both younger and older neighbours, so that decrement and hold happen in the same edge. A random stream does not produce this reliably in a freshly reset set. The stimulus therefore first drives a directed access to a middle way. It then repeats an access to the most recent way, drives idle cycles with a changing way index, and finally runs a long random stream. A recency-list model predicts every counter after each edge.

// File: rtl/lru_age_pkg.sv
`timescale 1ns/1ps
package lru_age_pkg;
  // Width of a way index / age counter; at least one bit.
  function automatic int idx_width(input int ways);
    return (ways <= 2) ? 1 : $clog2(ways);
  endfunction
endpackage

// File: rtl/lru_age_cell.sv
`timescale 1ns/1ps
module lru_age_cell #(
  parameter int unsigned AGE_W = 2,
  parameter logic [AGE_W-1:0] RESET_AGE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic             sel_i,
  input  logic [AGE_W-1:0] ref_age_i,
  output logic [AGE_W-1:0] age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

  logic [AGE_W-1:0] age_q, age_d;
  logic             age_en;

  always_comb begin
    age_en = touch_i;
    age_d  = age_q;
    if (sel_i) begin
      age_d = AGE_MAX;
    end else if (age_q > ref_age_i) begin
      age_d = age_q - AGE_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= RESET_AGE;
    end else if (age_en) begin
      age_q <= age_d;
    end
  end

  assign age_o = age_q;

  p_touch_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i && sel_i |=> age_o == AGE_MAX);
  p_dec_above_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i && !sel_i && (age_o > ref_age_i) |=> age_o == $past(age_o) - AGE_ONE);
  p_keep_below_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i && !sel_i && (age_o < ref_age_i) |=> $stable(age_o));
  p_mru_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i && (ref_age_i == AGE_MAX) |=> $stable(age_o));
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !touch_i |=> $stable(age_o));
endmodule

// File: rtl/lru_victim_pick.sv
`timescale 1ns/1ps
module lru_victim_pick #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [IDX_W-1:0] ages_i [WAYS],
  output logic [IDX_W-1:0] victim_o
);
  // Exactly one counter is zero, so an OR of the matching indices suffices.
  always_comb begin
    victim_o = '0;
    for (int j = 0; j < WAYS; j++) begin
      if (ages_i[j] == '0) victim_o = victim_o | IDX_W'(j);
    end
  end
endmodule

// File: rtl/lru_age_tracker.sv
`timescale 1ns/1ps
module lru_age_tracker #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned IDX_W = lru_age_pkg::idx_width(WAYS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  touch_i,
  input  logic [IDX_W-1:0]      touch_way_i,
  output logic [IDX_W-1:0]      victim_way_o,
  output logic [WAYS*IDX_W-1:0] ages_o
);
  logic [IDX_W-1:0] ages [WAYS];
  logic [IDX_W-1:0] ref_age;

  // Previous age of the accessed way (the X of the update rule).
  assign ref_age = ages[touch_way_i];

  for (genvar j = 0; j < WAYS; j++) begin : g_way
    lru_age_cell #(
      .AGE_W     (IDX_W),
      .RESET_AGE (IDX_W'(j))
    ) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .touch_i   (touch_i),
      .sel_i     (touch_way_i == IDX_W'(j)),
      .ref_age_i (ref_age),
      .age_o     (ages[j])
    );
    assign ages_o[j*IDX_W +: IDX_W] = ages[j];
  end

  lru_victim_pick #(
    .WAYS  (WAYS),
    .IDX_W (IDX_W)
  ) u_pick (
    .ages_i   (ages),
    .victim_o (victim_way_o)
  );

  p_victim_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ages[victim_way_o] == '0);

  // Each age value is held by exactly one way (R8).
  logic [WAYS-1:0] val_hit [WAYS];
  always_comb begin
    for (int v = 0; v < WAYS; v++) begin
      for (int j = 0; j < WAYS; j++) begin
        val_hit[v][j] = (ages[j] == IDX_W'(v));
      end
    end
  end

  for (genvar v = 0; v < WAYS; v++) begin : g_perm
    p_perm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(val_hit[v]) == 1);
  end
endmodule

// File: tb/lru_age_tracker_tb_top.sv
`timescale 1ns/1ps
module lru_age_tracker_tb_top;
  localparam int W  = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_ni;
  logic touch;
  logic [AW-1:0] way;
  logic [AW-1:0] victim;
  logic [W*AW-1:0] ages;

  logic touch2;
  logic way2;
  logic victim2;
  logic [1:0] ages2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lru_age_tracker #(.WAYS(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .touch_i(touch), .touch_way_i(way),
    .victim_way_o(victim), .ages_o(ages));

  lru_age_tracker #(.WAYS(2)) dut2_i (
    .clk_i(clk), .rst_ni(rst_ni), .touch_i(touch2), .touch_way_i(way2),
    .victim_way_o(victim2), .ages_o(ages2));

  typedef struct {
    string           tag;
    logic [W*AW-1:0] ages;
    logic [AW-1:0]   vic;
  } exp_t;

  exp_t sb[$];
  int   order[$];   // recency list, index 0 = least recent
  logic exp_vic2;

  function automatic exp_t model_item(string tag);
    exp_t e;
    e.tag  = tag;
    e.ages = '0;
    for (int p = 0; p < W; p++) e.ages[order[p]*AW +: AW] = AW'(p);
    e.vic = AW'(order[0]);
    return e;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(bit t, int w, string tag);
    @(negedge clk);
    touch  = t;
    way    = AW'(w);
    touch2 = t;
    way2   = w[0];
    @(posedge clk);
    #1;
    if (t) begin
      for (int p = 0; p < order.size(); p++) begin
        if (order[p] == w) begin
          order.delete(p);
          break;
        end
      end
      order.push_back(w);
      exp_vic2 = ~w[0];
    end
    sb.push_back(model_item(tag));
    check("R10 victim of two-way set", int'(victim2), int'(exp_vic2));
    touch  = 1'b0;
    touch2 = 1'b0;
  endtask

  // Monitor: pops expected items and compares, plus permutation check.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      int   cnt [W];
      e = sb.pop_front();
      check({e.tag, " ages"}, int'(ages), int'(e.ages));
      check("R7 R9 victim", int'(victim), int'(e.vic));
      for (int v = 0; v < W; v++) cnt[v] = 0;
      for (int j = 0; j < W; j++) cnt[int'(ages[j*AW +: AW])]++;
      for (int v = 0; v < W; v++) check("R8 value count", cnt[v], 1);
    end
  end

  initial begin
    rst_ni = 1'b0;
    touch  = 1'b0;
    way    = '0;
    touch2 = 1'b0;
    way2   = 1'b0;
    exp_vic2 = 1'b0;
    for (int j = 0; j < W; j++) order.push_back(j);
    repeat (3) @(negedge clk);
    check("R1 ages in reset", int'(ages), int'(8'b11_10_01_00));
    rst_ni = 1'b1;
    #1;
    sb.push_back(model_item("R1 after reset"));
    check("R10 reset victim", int'(victim2), 0);
    // middle way: way 3 decrements (R3), ways 0,1 hold (R4), way 2 to max (R2)
    access(1'b1, 2, "R2 R3 R4 middle");
    access(1'b1, 0, "R2 R3 oldest");
    access(1'b1, 0, "R5 repeat most recent");
    access(1'b1, 0, "R5 repeat again");
    for (int k = 0; k < 6; k++) access(1'b0, k % W, "R6 idle");
    access(1'b1, 1, "R3 R4 mixed");
    for (int k = 0; k < 400; k++) begin
      access(($urandom % 4) != 0, int'($urandom % W), "R9 random");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule